// File: doc/BRIEF.md
# Module Clock/Reset State Controller

This block manages the clock gate and the active-low reset of a group of modules that all sit in one always-on power domain. Each module has its own control word, which holds the state software wants, and its own status word, which holds the state the module is in now. Software stages the wanted states first. A single command then starts the controller, which works through the modules in index order. Each module whose wanted state differs from its present state is driven through a fixed order of clock and reset changes. A busy flag stays raised until the last module has been handled.

State codes: 0 = disabled (clock gated, reset asserted), 1 = synchronous reset (clock running, reset asserted), 3 = enabled (clock running, reset released). The sequencer FSM has four states. SQ_IDLE waits for the command. On a GO it takes the transition *idle→check* with module index 0. SQ_CHECK compares the wanted code with the present code of the current module. A match, or a mismatch with the quick flag set, takes *check→advance*. A mismatch with the quick flag clear takes *check→wait*. SQ_WAIT counts out the settle gap and then takes *wait→advance*. SQ_ADVANCE takes *advance→check* with the next index, or *advance→idle* after the last module. The *advance→idle* step also commits any control writes that were held while the controller was busy.

Address map (byte addresses): command 0x00, transfer status 0x04, control word of module i at 0x40+4i, status word of module i at 0x80+4i. Register reads are combinational.

Top module: `modclk_ctrl`

## Requirements
- R1: After power-on reset every status word reads 0, bit 0 of 0x04 reads 0, and every mod_clk_en and mod_rst_n bit is 0.
- R2: The control word keeps the wanted code in bits [1:0] and the quick flag in bit 9, and reads back at 0x40+4i. A written code of 2 is stored as 0. All other bits read 0.
- R3: Writing 1 to bit 0 of 0x00 while idle starts a transition. Bit 0 of 0x04 then reads 1 until every module has been handled, and reads 0 afterwards.
- R4: Once busy drops, bits [1:0] of the status word at 0x80+4i equal the requested code. The outputs then follow that code: code 3 gives clk_en=1 and rst_n=1, code 1 gives clk_en=1 and rst_n=0, and code 0 gives clk_en=0 and rst_n=0.
- R5: When a module goes to code 3, its clock enable changes before its reset is released.
- R6: When a module goes to code 0 or code 1, its reset is asserted before its clock enable changes.
- R7: With the quick flag clear, the second signal changes 4 clock cycles (HOLD_CYC) after the first. With the quick flag set, both signals change in the same cycle.
- R8: A module whose status already equals its requested code sees no output change and keeps its status.
- R9: A GO written while busy is ignored. No new transition starts when the current one ends.
- R10: A control write made while busy leaves the readback value unchanged until the transition ends, and takes effect at the end.
- R11: A module's reset is never released while its clock is gated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on bus_addr |
| mod_clk_en | output | N_MOD | Clock enable for each module |
| mod_rst_n | output | N_MOD | Active-low reset for each module |

## Verification
The bench tries every pair of start code and target code, each with the quick flag clear and set. For each case it measures the cycle in which each output first changes. A design that swapped the order of the two changes fails R5/R6. A design whose settle counter is off by one fails R7, and a design that touched matching modules fails R8. A separate case writes a control word and a GO while busy, then checks that the held value is committed without starting a second transition. A design that dropped held writes, applied them at once, or honoured the late GO is caught by that case. Writing the reserved code 2 checks that it reads back as 0.

// File: rtl/modclk_pkg.sv
package modclk_pkg;

    localparam logic [1:0] CODE_OFF  = 2'd0;
    localparam logic [1:0] CODE_SRST = 2'd1;
    localparam logic [1:0] CODE_ON   = 2'd3;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_CHECK,
        SQ_WAIT,
        SQ_ADVANCE
    } seq_e;

    typedef struct packed {
        logic       quick;
        logic [1:0] next;
    } mctrl_t;

    function automatic logic [1:0] clean_code(input logic [1:0] c);
        return (c == 2'd2) ? CODE_OFF : c;
    endfunction

    function automatic logic clk_of(input logic [1:0] c);
        return c != CODE_OFF;
    endfunction

    function automatic logic rstn_of(input logic [1:0] c);
        return c == CODE_ON;
    endfunction

endpackage

// File: rtl/modclk_regs.sv
module modclk_regs
    import modclk_pkg::*;
#(
    parameter int N_MOD      = 4,
    parameter int ADDR_W     = 8,
    parameter int CMD_ADDR   = 'h00,
    parameter int TSTAT_ADDR = 'h04,
    parameter int CTRL_BASE  = 'h40,
    parameter int STAT_BASE  = 'h80
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_we,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [31:0]                 bus_wdata,
    output logic [31:0]                 bus_rdata,
    input  logic                        busy,
    input  logic                        finish,
    input  logic [N_MOD-1:0][1:0]       stat_code,
    output mctrl_t [N_MOD-1:0]          ctrl_q,
    output logic                        go
);

    mctrl_t [N_MOD-1:0] pend_q;
    logic   [N_MOD-1:0] pend_v_q;
    logic   [N_MOD-1:0] wr_hit;
    mctrl_t             wr_val;
    logic               unused_wbits;

    assign unused_wbits = ^{bus_wdata[31:10], bus_wdata[8:2]};
    assign wr_val       = '{quick: bus_wdata[9], next: clean_code(bus_wdata[1:0])};
    assign go           = bus_we && (bus_addr == ADDR_W'(CMD_ADDR)) && bus_wdata[0] && !busy;

    generate
        for (genvar g = 0; g < N_MOD; g++) begin : g_hit
            assign wr_hit[g] = bus_we && (bus_addr == ADDR_W'(CTRL_BASE + 4 * g));
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            pend_q   <= '0;
            pend_v_q <= '0;
        end else begin
            for (int i = 0; i < N_MOD; i++) begin
                if (finish) begin
                    if (wr_hit[i])        ctrl_q[i] <= wr_val;
                    else if (pend_v_q[i]) ctrl_q[i] <= pend_q[i];
                    pend_v_q[i] <= 1'b0;
                end else if (busy) begin
                    if (wr_hit[i]) begin
                        pend_q[i]   <= wr_val;
                        pend_v_q[i] <= 1'b1;
                    end
                end else if (wr_hit[i]) begin
                    ctrl_q[i] <= wr_val;
                end
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(TSTAT_ADDR)) bus_rdata[0] = busy;
        for (int i = 0; i < N_MOD; i++) begin
            if (bus_addr == ADDR_W'(CTRL_BASE + 4 * i)) begin
                bus_rdata[9]   = ctrl_q[i].quick;
                bus_rdata[1:0] = ctrl_q[i].next;
            end
            if (bus_addr == ADDR_W'(STAT_BASE + 4 * i)) bus_rdata[1:0] = stat_code[i];
        end
    end

    // R10: staged control stays frozen while a transition runs
    a_r10_ctrl_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !finish) |=> $stable(ctrl_q));

    // R9: a GO is never produced while busy
    a_r9_no_go_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !go);

endmodule

// File: rtl/modclk_seq.sv
module modclk_seq
    import modclk_pkg::*;
#(
    parameter int N_MOD    = 4,
    parameter int HOLD_CYC = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  go,
    input  mctrl_t [N_MOD-1:0]    ctrl_q,
    output logic                  busy,
    output logic                  finish,
    output logic [N_MOD-1:0][1:0] stat_code,
    output logic [N_MOD-1:0]      mod_clk_en,
    output logic [N_MOD-1:0]      mod_rst_n
);

    localparam int IDX_W = (N_MOD > 1) ? $clog2(N_MOD) : 1;
    localparam int CNT_W = $clog2(HOLD_CYC + 1);

    seq_e             state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic [CNT_W-1:0] cnt_q;
    logic             last, mismatch, quick, step1, step2;
    logic [1:0]       target;

    assign target   = ctrl_q[idx_q].next;
    assign quick    = ctrl_q[idx_q].quick;
    assign mismatch = target != stat_code[idx_q];
    assign last     = idx_q == IDX_W'(N_MOD - 1);
    assign busy     = state_q != SQ_IDLE;
    assign finish   = (state_q == SQ_ADVANCE) && last;
    assign step1    = (state_q == SQ_CHECK) && mismatch;
    assign step2    = (step1 && quick) || ((state_q == SQ_WAIT) && (cnt_q == '0));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE:    if (go) state_d = SQ_CHECK;
            SQ_CHECK:   state_d = (mismatch && !quick) ? SQ_WAIT : SQ_ADVANCE;
            SQ_WAIT:    if (cnt_q == '0) state_d = SQ_ADVANCE;
            SQ_ADVANCE: state_d = last ? SQ_IDLE : SQ_CHECK;
            default:    state_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            idx_q   <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == SQ_IDLE && go)        idx_q <= '0;
            if (state_q == SQ_ADVANCE && !last)  idx_q <= idx_q + 1'b1;
            if (state_q == SQ_CHECK)             cnt_q <= CNT_W'(HOLD_CYC - 1);
            else if (state_q == SQ_WAIT)         cnt_q <= cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_code  <= '0;
            mod_clk_en <= '0;
            mod_rst_n  <= '0;
        end else begin
            for (int i = 0; i < N_MOD; i++) begin
                if (idx_q == IDX_W'(i)) begin
                    if (step1) begin
                        if (target == CODE_ON) mod_clk_en[i] <= 1'b1;
                        else                   mod_rst_n[i]  <= 1'b0;
                    end
                    if (step2) begin
                        mod_clk_en[i] <= clk_of(target);
                        mod_rst_n[i]  <= rstn_of(target);
                        stat_code[i]  <= target;
                    end
                end
            end
        end
    end

    // R3: busy only rises as the result of a GO
    a_r3_busy_from_go: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(go));

    // R8: status words never move while idle
    a_r8_stat_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(stat_code));

    generate
        for (genvar g = 0; g < N_MOD; g++) begin : g_chk
            // R11: reset is released only with the clock running
            a_r11_rst_needs_clk: assert property (@(posedge clk) disable iff (!rst_n)
                mod_rst_n[g] |-> mod_clk_en[g]);
            // R4: when idle, outputs agree with the reported state
            a_r4_idle_match: assert property (@(posedge clk) disable iff (!rst_n)
                !busy |-> (mod_clk_en[g] == clk_of(stat_code[g]) &&
                           mod_rst_n[g]  == rstn_of(stat_code[g])));
        end
    endgenerate

endmodule

// File: rtl/modclk_ctrl.sv
module modclk_ctrl
    import modclk_pkg::*;
#(
    parameter int N_MOD    = 4,
    parameter int ADDR_W   = 8,
    parameter int HOLD_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [N_MOD-1:0]  mod_clk_en,
    output logic [N_MOD-1:0]  mod_rst_n
);

    mctrl_t [N_MOD-1:0]    ctrl_q;
    logic [N_MOD-1:0][1:0] stat_code;
    logic                  busy, finish, go;

    modclk_regs #(.N_MOD(N_MOD), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (busy),
        .finish    (finish),
        .stat_code (stat_code),
        .ctrl_q    (ctrl_q),
        .go        (go)
    );

    modclk_seq #(.N_MOD(N_MOD), .HOLD_CYC(HOLD_CYC)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .ctrl_q     (ctrl_q),
        .busy       (busy),
        .finish     (finish),
        .stat_code  (stat_code),
        .mod_clk_en (mod_clk_en),
        .mod_rst_n  (mod_rst_n)
    );

endmodule

// File: tb/modclk_ctrl_tb.sv
module modclk_ctrl_tb;

    localparam int N    = 4;
    localparam int HOLD = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [N-1:0] mod_clk_en, mod_rst_n;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    int clk_t [N];
    int rst_t [N];

    always #4 clk = ~clk;

    modclk_ctrl #(.N_MOD(N), .ADDR_W(8), .HOLD_CYC(HOLD)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mod_clk_en(mod_clk_en), .mod_rst_n(mod_rst_n)
    );

    function automatic logic [7:0] a_ctrl(input int m); return 8'(8'h40 + 4 * m); endfunction
    function automatic logic [7:0] a_stat(input int m); return 8'(8'h80 + 4 * m); endfunction
    function automatic logic ck_of(input int c); return c != 0; endfunction
    function automatic logic rn_of(input int c); return c == 3; endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic go_and_watch();
        logic [N-1:0] c0, r0;
        logic [31:0]  st;
        c0 = mod_clk_en; r0 = mod_rst_n;
        for (int i = 0; i < N; i++) begin clk_t[i] = -1; rst_t[i] = -1; end
        wr(8'h00, 32'h1);
        rd(8'h04, st);
        chk("R3 busy after GO", int'(st[0]), 1);
        for (int k = 0; k < 300; k++) begin
            for (int i = 0; i < N; i++) begin
                if (clk_t[i] < 0 && mod_clk_en[i] != c0[i]) clk_t[i] = k;
                if (rst_t[i] < 0 && mod_rst_n[i] != r0[i])  rst_t[i] = k;
            end
            rd(8'h04, st);
            if (!st[0]) break;
            @(negedge clk);
        end
        chk("R3 busy cleared", int'(st[0]), 0);
    endtask

    initial begin
        while (cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=<100000", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int codes [3];
        int m, combo, gap, cf, cr;
        codes[0] = 0; codes[1] = 1; codes[2] = 3;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8'h04, v); chk("R1 busy", int'(v[0]), 0);
        for (int i = 0; i < N; i++) begin
            rd(a_stat(i), v); chk("R1 stat", int'(v), 0);
        end
        chk("R1 clk_en", int'(mod_clk_en), 0);
        chk("R1 rst_n", int'(mod_rst_n), 0);

        // R2 control word fields
        wr(a_ctrl(3), 32'hFFFF_FFFE); rd(a_ctrl(3), v); chk("R2 code2 quick", int'(v), 32'h200);
        wr(a_ctrl(3), 32'h0000_0203); rd(a_ctrl(3), v); chk("R2 code3 quick", int'(v), 32'h203);
        wr(a_ctrl(3), 32'h0000_0002); rd(a_ctrl(3), v); chk("R2 code2 plain", int'(v), 0);

        // Sweep every start/target code pair with both quick settings
        combo = 0;
        for (int f = 0; f < 3; f++) begin
            for (int t = 0; t < 3; t++) begin
                for (int q = 0; q < 2; q++) begin
                    m = combo % N;
                    combo++;
                    wr(a_ctrl(m), 32'(codes[f]) | 32'h200);
                    go_and_watch();
                    wr(a_ctrl(m), 32'(codes[t]) | (q != 0 ? 32'h200 : 32'h0));
                    go_and_watch();
                    rd(a_stat(m), v);
                    chk("R4 stat", int'(v), codes[t]);
                    chk("R4 clk_en", int'(mod_clk_en[m]), int'(ck_of(codes[t])));
                    chk("R4 rst_n", int'(mod_rst_n[m]), int'(rn_of(codes[t])));
                    for (int o = 0; o < N; o++) begin
                        if (o != m) begin
                            chk("R8 other clk", clk_t[o], -1);
                            chk("R8 other rst", rst_t[o], -1);
                        end
                    end
                    if (f == t) begin
                        chk("R8 match clk", clk_t[m], -1);
                        chk("R8 match rst", rst_t[m], -1);
                    end else if (ck_of(codes[f]) != ck_of(codes[t]) &&
                                 rn_of(codes[f]) != rn_of(codes[t])) begin
                        gap = (q != 0) ? 0 : HOLD;
                        cf = clk_t[m]; cr = rst_t[m];
                        if (codes[t] == 3) chk("R5 R7 clk then reset gap", cr - cf, gap);
                        else               chk("R6 R7 reset then clk gap", cf - cr, gap);
                    end
                end
            end
        end

        // R9 / R10: writes and GO during busy
        for (int i = 0; i < N; i++) wr(a_ctrl(i), 32'h200);
        go_and_watch();
        wr(a_ctrl(1), 32'h3);
        wr(8'h00, 32'h1);
        wr(a_ctrl(2), 32'h3);
        rd(a_ctrl(2), v); chk("R10 readback held", int'(v), 32'h200);
        wr(8'h00, 32'h1);
        for (int k = 0; k < 300; k++) begin
            rd(8'h04, v);
            if (!v[0]) break;
            @(negedge clk);
        end
        rd(a_ctrl(2), v); chk("R10 committed", int'(v), 3);
        repeat (20) @(negedge clk);
        rd(8'h04, v); chk("R9 stays idle", int'(v[0]), 0);
        rd(a_stat(2), v); chk("R9 no new transition", int'(v), 0);
        chk("R9 clk untouched", int'(mod_clk_en[2]), 0);
        rd(a_stat(1), v); chk("R4 first transition", int'(v), 3);
        go_and_watch();
        rd(a_stat(2), v); chk("R10 applied by next GO", int'(v), 3);
        chk("R11 reset with clock", int'(mod_rst_n & ~mod_clk_en), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule